// File: doc/BRIEF.md
# Banked Lookup-Table Loader

This block is the register-side loader for a colour lookup table that is split into eight sub-memories. A CPU reaches it through a simple memory-mapped slave. Software reads fixed words that describe how the table was built, sets a global control word, and loads each sub-memory indirectly. For each entry it first puts the entry value into one or two staging data registers. It then writes that sub-memory's control register with the entry address and a commit bit. The commit bit has effect only on the cycle it is written and always reads back as zero.

The table can be built double-buffered. In that case each sub-memory holds two banks. The pixel side reads from the active bank, and the CPU loads and reads back the other bank. A bank-select request from software is applied only on an end-of-frame pulse, so a single frame never sees a mix of old and new table contents. The pixel side presents one address per sub-memory every cycle and gets the entry back one cycle later. The global enable bit is brought out so the downstream datapath can bypass the table.

Top module: `lut_prog_top`

## Requirements
- R1: Byte offset 0x000 reads {vendor code 0x5A17 in bits 31:16, product code 0x0C3D in bits 15:0}. Offset 0x004 reads {major 2, minor 1} in the same halves. Offsets 0x00C, 0x010, 0x014, 0x018, 0x01C, 0x020, 0x024 and 0x028 read, in that order, the pixels-in-parallel count (1), input bits per sample (10), output bits per sample (10), alpha flag (1), table bits per colour (10), table size (17), double-buffer flag (1) and read-back flag (1).
- R2: Every unmapped offset reads zero. This includes 0x008, 0x030, 0x14C, slot 0x184+0x10*n, and anything at or above 0x200. Writes to read-only or unmapped offsets change nothing that can be read back.
- R3: Every read or write request is acknowledged exactly once, on the cycle after the request. No acknowledge appears without a request.
- R4: The control word at 0x148 holds enable in bit 0 and bank request in bit 1. Its other bits read zero. Output `lut_enable` follows bit 0 from the cycle after the write. After reset, enable, bank request, `active_bank` and `cpu_ack` are all zero.
- R5: The control register of sub-memory n sits at 0x180+0x10*n. It returns the last written bits 16:0 as the entry address. Bit 28 (commit) and all other bits read zero.
- R6: A control write with bit 28 set stores the staged value {upper[7:0], lower[31:0]} (40-bit entry) at the address in bits 5:0, in sub-memory n only. A control write with bit 28 clear stores nothing.
- R7: The lower data register at 0x188+0x10*n returns bits 31:0 of the stored entry at the address last written to that sub-memory's control register.
- R8: The entry is 40 bits wide ((1+3)*10 > 32), so the upper data register at 0x18C+0x10*n exists. It returns entry bits 39:32 in bits 7:0 and zero above.
- R9: `active_bank` takes the bank-request bit only on a cycle where `frame_end` is high. Otherwise it holds.
- R10: CPU commits and read-back act on the bank opposite to `active_bank`. Loading one bank never changes what the pixel side reads from the other.
- R11: For each sub-memory, `pix_data` slice n returns the entry at `pix_addr` slice n in the active bank, one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 10 | Byte address, 32-bit aligned |
| cpu_wr | input | 1 | Write request |
| cpu_rd | input | 1 | Read request |
| cpu_wdata | input | 32 | Write data |
| cpu_ack | output | 1 | Acknowledge, one cycle after a request |
| cpu_rdata | output | 32 | Read data, valid with acknowledge |
| frame_end | input | 1 | End-of-frame pulse that applies the bank request |
| pix_addr | input | 48 | Eight 6-bit entry addresses, one per sub-memory |
| pix_data | output | 320 | Eight 40-bit entries, one cycle after the addresses |
| lut_enable | output | 1 | Table enable; low means bypass |
| active_bank | output | 1 | Bank the pixel side reads |

## Verification
A wrong bank register shows up at once. The pixel port returns the other bank's entries on the next cycle, and a read-back of a just-committed entry returns stale data. A stuck or misrouted staging or address register appears on the first data read that follows a commit, and the wrong value lands in a sub-memory that was not addressed. A bank switch outside a frame-end pulse changes `active_bank` on the cycle it happens. Because the reference model predicts acknowledge, read data, enable, bank and every pixel slice on each clock, any divergence is reported within one cycle of becoming visible.

// File: rtl/lut_prog_pkg.sv
package lut_prog_pkg;
  localparam int unsigned BUS_AW = 10;
  localparam int unsigned ENTRY_ADDR_W = 17;
  localparam int unsigned COMMIT_BIT = 28;

  localparam logic [BUS_AW-1:0] OFS_ID    = 10'h000;
  localparam logic [BUS_AW-1:0] OFS_VER   = 10'h004;
  localparam logic [BUS_AW-1:0] OFS_PIP   = 10'h00C;
  localparam logic [BUS_AW-1:0] OFS_IBPS  = 10'h010;
  localparam logic [BUS_AW-1:0] OFS_OBPS  = 10'h014;
  localparam logic [BUS_AW-1:0] OFS_ALPHA = 10'h018;
  localparam logic [BUS_AW-1:0] OFS_BPC   = 10'h01C;
  localparam logic [BUS_AW-1:0] OFS_SIZE  = 10'h020;
  localparam logic [BUS_AW-1:0] OFS_DBUF  = 10'h024;
  localparam logic [BUS_AW-1:0] OFS_RDBK  = 10'h028;
  localparam logic [BUS_AW-1:0] OFS_CTRL  = 10'h148;

  // address bits 9:7 select the sub-memory window (0x180..0x1FF)
  localparam logic [2:0] RAM_WINDOW = 3'b011;

  typedef enum logic [1:0] {
    SLOT_CTRL = 2'd0,
    SLOT_GAP  = 2'd1,
    SLOT_LO   = 2'd2,
    SLOT_HI   = 2'd3
  } slot_e;
endpackage

// File: rtl/lut_subram.sv
module lut_subram #(
  parameter int unsigned DW = 40,
  parameter int unsigned AW = 7
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/lut_bank_ctrl.sv
module lut_bank_ctrl #(
  parameter bit DOUBLE_BUF = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ctrl_wr,
  input  logic [1:0] ctrl_bits,
  input  logic       frame_end,
  output logic       en_q,
  output logic       req_q,
  output logic       active_q,
  output logic       cpu_bank
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      req_q    <= 1'b0;
      active_q <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        en_q  <= ctrl_bits[0];
        req_q <= ctrl_bits[1];
      end
      // the request held before this edge is what a frame end applies
      if (frame_end && DOUBLE_BUF) active_q <= req_q;
    end
  end

  assign cpu_bank = DOUBLE_BUF ? ~active_q : 1'b0;
endmodule

// File: rtl/lut_mem_port.sv
module lut_mem_port
  import lut_prog_pkg::*;
#(
  parameter int unsigned DW         = 40,
  parameter int unsigned MEM_AW     = 6,
  parameter bit          DOUBLE_BUF = 1'b1,
  parameter bit          READBACK   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              cpu_wr,
  input  slot_e             slot,
  input  logic [31:0]       wdata,
  input  logic              cpu_bank,
  input  logic              pix_bank,
  input  logic [MEM_AW-1:0] pix_addr,
  output logic [DW-1:0]     pix_data,
  input  slot_e             rd_slot,
  output logic [31:0]       rd_value
);
  localparam bit          HAS_UPPER = (DW > 32);
  localparam int unsigned BANK_W    = DOUBLE_BUF ? 1 : 0;
  localparam int unsigned RAM_AW    = MEM_AW + BANK_W;

  logic [ENTRY_ADDR_W-1:0] addr_q;
  logic [31:0]             lo_q, hi_q;
  logic                    wr_ctrl, commit;
  logic [63:0]             stage64, rb64;
  logic [DW-1:0]           rb_entry;
  logic [MEM_AW-1:0]       cpu_row;
  logic [RAM_AW-1:0]       ram_a, ram_b;

  assign wr_ctrl = sel && cpu_wr && (slot == SLOT_CTRL);
  assign commit  = wr_ctrl && wdata[COMMIT_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else begin
      if (wr_ctrl) addr_q <= wdata[ENTRY_ADDR_W-1:0];
      if (sel && cpu_wr && slot == SLOT_LO) lo_q <= wdata;
      if (sel && cpu_wr && slot == SLOT_HI && HAS_UPPER) hi_q <= wdata;
    end
  end

  assign stage64 = {hi_q, lo_q};
  // the write row comes straight from the bus so a later read sees it
  assign cpu_row = commit ? wdata[MEM_AW-1:0] : addr_q[MEM_AW-1:0];

  generate
    if (DOUBLE_BUF) begin : g_banked
      assign ram_a = {cpu_bank, cpu_row};
      assign ram_b = {pix_bank, pix_addr};
    end else begin : g_single
      assign ram_a = cpu_row;
      assign ram_b = pix_addr;
    end
  endgenerate

  lut_subram #(.DW(DW), .AW(RAM_AW)) u_ram (
    .clk     (clk),
    .a_we    (commit),
    .a_addr  (ram_a),
    .a_wdata (stage64[DW-1:0]),
    .a_rdata (rb_entry),
    .b_addr  (ram_b),
    .b_rdata (pix_data)
  );

  assign rb64 = 64'(rb_entry);

  always_comb begin
    case (rd_slot)
      SLOT_CTRL: rd_value = 32'(addr_q);
      SLOT_LO:   rd_value = READBACK ? rb64[31:0] : lo_q;
      SLOT_HI:   rd_value = !HAS_UPPER ? 32'd0 : (READBACK ? rb64[63:32] : hi_q);
      default:   rd_value = 32'd0;
    endcase
  end
endmodule

// File: rtl/lut_prog_top.sv
module lut_prog_top
  import lut_prog_pkg::*;
#(
  parameter int unsigned PIXELS_PAR = 1,
  parameter int unsigned IN_BPS     = 10,
  parameter int unsigned OUT_BPS    = 10,
  parameter int unsigned ALPHA_OUT  = 1,
  parameter int unsigned LUT_BPC    = 10,
  parameter int unsigned LUT_SIZE   = 17,
  parameter bit          DOUBLE_BUF = 1'b1,
  parameter bit          READBACK   = 1'b1,
  parameter int unsigned NUM_MEM    = 8,
  parameter int unsigned MEM_AW     = 6,
  parameter logic [15:0] PRODUCT_ID = 16'h0C3D,
  parameter logic [15:0] VENDOR_ID  = 16'h5A17,
  parameter logic [15:0] VER_MAJOR  = 16'd2,
  parameter logic [15:0] VER_MINOR  = 16'd1,
  localparam int unsigned DW        = (ALPHA_OUT + 3) * LUT_BPC
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [BUS_AW-1:0]         cpu_addr,
  input  logic                      cpu_wr,
  input  logic                      cpu_rd,
  input  logic [31:0]               cpu_wdata,
  output logic                      cpu_ack,
  output logic [31:0]               cpu_rdata,
  input  logic                      frame_end,
  input  logic [NUM_MEM*MEM_AW-1:0] pix_addr,
  output logic [NUM_MEM*DW-1:0]     pix_data,
  output logic                      lut_enable,
  output logic                      active_bank
);
  localparam logic [3:0] NUM_MEM_L = 4'(NUM_MEM);

  logic        in_window, ctrl_wr;
  logic [2:0]  grp;
  slot_e       slot;
  logic [31:0] fixed_word;
  logic        en_q, req_q, active_q, cpu_bank;

  logic        ack_q, src_ram_q;
  logic [2:0]  rd_grp_q;
  slot_e       rd_slot_q;
  logic [31:0] rd_word_q;
  logic [31:0] grp_val [NUM_MEM];

  assign grp       = cpu_addr[6:4];
  assign slot      = slot_e'(cpu_addr[3:2]);
  assign in_window = (cpu_addr[9:7] == RAM_WINDOW) && ({1'b0, grp} < NUM_MEM_L);
  assign ctrl_wr   = cpu_wr && (cpu_addr == OFS_CTRL);

  lut_bank_ctrl #(.DOUBLE_BUF(DOUBLE_BUF)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .ctrl_wr   (ctrl_wr),
    .ctrl_bits (cpu_wdata[1:0]),
    .frame_end (frame_end),
    .en_q      (en_q),
    .req_q     (req_q),
    .active_q  (active_q),
    .cpu_bank  (cpu_bank)
  );

  generate
    for (genvar n = 0; n < NUM_MEM; n++) begin : g_mem
      lut_mem_port #(
        .DW(DW), .MEM_AW(MEM_AW), .DOUBLE_BUF(DOUBLE_BUF), .READBACK(READBACK)
      ) u_port (
        .clk      (clk),
        .rst      (rst),
        .sel      (in_window && (grp == 3'(n))),
        .cpu_wr   (cpu_wr),
        .slot     (slot),
        .wdata    (cpu_wdata),
        .cpu_bank (cpu_bank),
        .pix_bank (active_q),
        .pix_addr (pix_addr[n*MEM_AW +: MEM_AW]),
        .pix_data (pix_data[n*DW +: DW]),
        .rd_slot  (rd_slot_q),
        .rd_value (grp_val[n])
      );
    end
  endgenerate

  always_comb begin
    case (cpu_addr)
      OFS_ID:    fixed_word = {VENDOR_ID, PRODUCT_ID};
      OFS_VER:   fixed_word = {VER_MAJOR, VER_MINOR};
      OFS_PIP:   fixed_word = 32'(PIXELS_PAR);
      OFS_IBPS:  fixed_word = 32'(IN_BPS);
      OFS_OBPS:  fixed_word = 32'(OUT_BPS);
      OFS_ALPHA: fixed_word = 32'(ALPHA_OUT);
      OFS_BPC:   fixed_word = 32'(LUT_BPC);
      OFS_SIZE:  fixed_word = 32'(LUT_SIZE);
      OFS_DBUF:  fixed_word = 32'(DOUBLE_BUF);
      OFS_RDBK:  fixed_word = 32'(READBACK);
      OFS_CTRL:  fixed_word = {30'd0, req_q, en_q};
      default:   fixed_word = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q     <= 1'b0;
      src_ram_q <= 1'b0;
      rd_grp_q  <= '0;
      rd_slot_q <= SLOT_GAP;
      rd_word_q <= '0;
    end else begin
      ack_q <= cpu_rd || cpu_wr;
      if (cpu_rd) begin
        src_ram_q <= in_window;
        rd_grp_q  <= grp;
        rd_slot_q <= slot;
        rd_word_q <= fixed_word;
      end
    end
  end

  assign cpu_ack     = ack_q;
  assign cpu_rdata   = !ack_q ? 32'd0 : (src_ram_q ? grp_val[rd_grp_q] : rd_word_q);
  assign lut_enable  = en_q;
  assign active_bank = active_q;
endmodule

// File: rtl/lut_prog_chk.sv
module lut_prog_chk
  import lut_prog_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [BUS_AW-1:0] cpu_addr,
  input logic              cpu_wr,
  input logic              cpu_rd,
  input logic [31:0]       cpu_wdata,
  input logic              cpu_ack,
  input logic [31:0]       cpu_rdata,
  input logic              frame_end,
  input logic              lut_enable,
  input logic              active_bank
);
  p_ack_follow_r3: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd || cpu_wr) |=> cpu_ack);

  p_ack_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !(cpu_rd || cpu_wr) |=> !cpu_ack);

  p_bank_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> $stable(active_bank));

  p_enable_write_r4: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr == OFS_CTRL) |=> (lut_enable == $past(cpu_wdata[0])));

  p_commit_reads_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_addr[9:7] == RAM_WINDOW && cpu_addr[3:2] == 2'd0)
      |=> (cpu_rdata[COMMIT_BIT] == 1'b0));

  p_gap_reads_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_addr == 10'h008) |=> (cpu_rdata == 32'd0));
endmodule

bind lut_prog_top lut_prog_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .cpu_addr    (cpu_addr),
  .cpu_wr      (cpu_wr),
  .cpu_rd      (cpu_rd),
  .cpu_wdata   (cpu_wdata),
  .cpu_ack     (cpu_ack),
  .cpu_rdata   (cpu_rdata),
  .frame_end   (frame_end),
  .lut_enable  (lut_enable),
  .active_bank (active_bank)
);

// File: tb/lut_prog_top_tb_top.sv
module lut_prog_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 8;
  localparam int MAW = 6;
  localparam int DW = 40;
  localparam int WATCHDOG = 20000;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [9:0]      cpu_addr = '0;
  logic            cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [31:0]     cpu_wdata = '0;
  logic            cpu_ack;
  logic [31:0]     cpu_rdata;
  logic            frame_end = 1'b0;
  logic [NM*MAW-1:0] pix_addr = '0;
  logic [NM*DW-1:0]  pix_data;
  logic            lut_enable, active_bank;

  lut_prog_top dut_i (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .frame_end(frame_end), .pix_addr(pix_addr), .pix_data(pix_data),
    .lut_enable(lut_enable), .active_bank(active_bank)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0, cycles = 0;
  string cur_tag = "R1";

  // reference model state
  int          en_m = 0, req_m = 0, act_m = 0;
  logic [16:0] addr_m [NM];
  logic [31:0] lo_m [NM], hi_m [NM];
  logic [DW-1:0] mem_m [int];

  // expectations for the following negedge
  bit          started = 0, exp_ack = 0, exp_rd = 0;
  logic [31:0] exp_rdata = '0;
  string       exp_tag = "R1";
  bit          pix_known [NM];
  logic [DW-1:0] exp_pix [NM];

  function automatic int key(int bank, int n, int a);
    return bank * 100000 + n * 1000 + a;
  endfunction

  function automatic logic [31:0] model_read(logic [9:0] a);
    int n, k;
    logic [DW-1:0] e;
    case (a)
      10'h000: return 32'h5A17_0C3D;
      10'h004: return 32'h0002_0001;
      10'h00C: return 1;
      10'h010: return 10;
      10'h014: return 10;
      10'h018: return 1;
      10'h01C: return 10;
      10'h020: return 17;
      10'h024: return 1;
      10'h028: return 1;
      10'h148: return {30'd0, req_m[0], en_m[0]};
      default: begin
        if (a[9:7] != 3'b011) return 0;
        n = int'(a[6:4]);
        if (a[3:2] == 2'd0) return {15'd0, addr_m[n]};
        if (a[3:2] == 2'd1) return 0;
        k = key(1 - act_m, n, int'(addr_m[n][MAW-1:0]));
        e = mem_m.exists(k) ? mem_m[k] : '0;
        if (a[3:2] == 2'd2) return e[31:0];
        return {24'd0, e[39:32]};
      end
    endcase
  endfunction

  task automatic model_write(logic [9:0] a, logic [31:0] d);
    int n;
    if (a == 10'h148) begin
      en_m = d[0]; req_m = d[1];
    end else if (a[9:7] == 3'b011) begin
      n = int'(a[6:4]);
      case (a[3:2])
        2'd0: begin
          addr_m[n] = d[16:0];
          if (d[28]) mem_m[key(1 - act_m, n, int'(d[MAW-1:0]))] = {hi_m[n][7:0], lo_m[n]};
        end
        2'd2: lo_m[n] = d;
        2'd3: hi_m[n] = d;
        default: ;
      endcase
    end
  endtask

  always @(posedge clk) begin
    int old_req, k;
    cycles++;
    started = 1;
    if (rst) begin
      en_m = 0; req_m = 0; act_m = 0;
      for (int n = 0; n < NM; n++) begin
        addr_m[n] = '0; lo_m[n] = '0; hi_m[n] = '0; pix_known[n] = 0;
      end
      exp_ack = 0; exp_rd = 0; exp_tag = "R4";
    end else begin
      exp_tag = cur_tag;
      exp_ack = cpu_rd || cpu_wr;
      exp_rd  = cpu_rd;
      if (cpu_rd) exp_rdata = model_read(cpu_addr);
      for (int n = 0; n < NM; n++) begin
        k = key(act_m, n, int'(pix_addr[n*MAW +: MAW]));
        pix_known[n] = mem_m.exists(k);
        if (pix_known[n]) exp_pix[n] = mem_m[k];
      end
      old_req = req_m;
      if (cpu_wr) model_write(cpu_addr, cpu_wdata);
      if (frame_end) act_m = old_req;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk("R3", 64'(cpu_ack), 64'(exp_ack));
      if (exp_ack && exp_rd) chk(exp_tag, 64'(cpu_rdata), 64'(exp_rdata));
      chk("R4", 64'(lut_enable), 64'(en_m[0]));
      chk("R9", 64'(active_bank), 64'(act_m[0]));
      for (int n = 0; n < NM; n++)
        if (pix_known[n]) chk("R11", 64'(pix_data[n*DW +: DW]), 64'(exp_pix[n]));
    end
    if (cycles > WATCHDOG) begin
      bad++; total++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(logic [9:0] a, logic [31:0] d);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd(logic [9:0] a);
    cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0;
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(int n, int a, logic [39:0] v);
    wr(10'(12'h188 + 16 * n), v[31:0]);
    wr(10'(12'h18C + 16 * n), {24'd0, v[39:32]});
    wr(10'(12'h180 + 16 * n), 32'h1000_0000 | 32'(a));
  endtask

  task automatic eof_pulse();
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(2);

    cur_tag = "R1";
    for (int i = 0; i < 11; i++) begin
      if (i == 2) continue;
      rd(10'(4 * i));
    end

    cur_tag = "R2";
    rd(10'h008); rd(10'h030); rd(10'h14C); rd(10'h184); rd(10'h200); rd(10'h3FC);
    wr(10'h000, 32'hFFFF_FFFF); wr(10'h00C, 32'h55); wr(10'h184, 32'hDEAD_BEEF);
    wr(10'h14C, 32'h3);
    rd(10'h000); rd(10'h00C); rd(10'h184); rd(10'h148);

    cur_tag = "R4";
    wr(10'h148, 32'hFFFF_FFFD); rd(10'h148); idle(2);

    cur_tag = "R5";
    wr(10'h1B0, 32'h0001_ABCD); rd(10'h1B0);
    wr(10'h1B0, 32'hFFFF_FFFF); rd(10'h1B0);

    // R6 R10: load the inactive bank (bank 1) of every sub-memory
    cur_tag = "R6";
    for (int n = 0; n < NM; n++)
      for (int a = 0; a < 8; a++)
        load(n, a, {8'(8'hA0 + n), 8'(n), 8'(a), 16'(16'h1234 + 7 * a + 97 * n)});

    cur_tag = "R7";
    for (int n = 0; n < NM; n++) begin
      wr(10'(12'h180 + 16 * n), 32'(n % 8));
      rd(10'(12'h188 + 16 * n));
    end

    cur_tag = "R8";
    for (int n = 0; n < NM; n++) rd(10'(12'h18C + 16 * n));
    wr(10'h1DC, 32'hFFFF_FFAB); wr(10'h1D8, 32'h0BAD_F00D); wr(10'h1D0, 32'h1000_0021);
    rd(10'h1DC); rd(10'h1D8);

    cur_tag = "R6";
    wr(10'h1D8, 32'h7777_7777); wr(10'h1D0, 32'h0000_0021);
    rd(10'h1D8); rd(10'h1DC);
    wr(10'h1E0, 32'h0000_0021); rd(10'h1E8);

    cur_tag = "R9";
    wr(10'h148, 32'h3); idle(6);
    for (int p = 0; p < 8; p++) begin
      for (int n = 0; n < NM; n++) pix_addr[n*MAW +: MAW] = 6'((p + n) % 8);
      @(negedge clk);
    end
    eof_pulse();

    cur_tag = "R11";
    for (int p = 0; p < 16; p++) begin
      for (int n = 0; n < NM; n++) pix_addr[n*MAW +: MAW] = 6'((p * 3 + n) % 8);
      @(negedge clk);
    end

    cur_tag = "R10";
    for (int n = 0; n < NM; n += 3)
      for (int a = 0; a < 8; a += 2)
        load(n, a, {8'(8'h50 + a), 32'(32'hC0DE_0000 + 16 * n + a)});
    for (int n = 0; n < NM; n += 3) begin
      wr(10'(12'h180 + 16 * n), 32'd4);
      rd(10'(12'h188 + 16 * n)); rd(10'(12'h18C + 16 * n));
    end
    wr(10'h148, 32'h1); eof_pulse(); eof_pulse();

    cur_tag = "R11";
    for (int p = 0; p < 16; p++) begin
      for (int n = 0; n < NM; n++) pix_addr[n*MAW +: MAW] = 6'((p + 5 * n) % 8);
      @(negedge clk);
    end
    rd(10'h148);

    idle(3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule